// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel with six behaviours selected when a count is loaded. The modes are: an event counter that raises its output at terminal count, a retriggerable one-shot, a rate generator, a square-wave generator, and software- and hardware-started strobes. Counting advances only on cycles where the tick enable is high. A gate input either qualifies counting or, through its rising edge, restarts the current period, depending on the mode.

The surrounding chip decodes the host's control words into a 3-bit mode, a BCD flag and a count-load strobe with a 16-bit initial value. It also reads the current count from this channel. A loaded value of zero means the longest possible period. The count register holds a binary value. The BCD flag changes only the full-count and wrap values: the full count becomes 10000 and the wrap value becomes 9999 decimal (0x270F), in place of 65536 and 0xFFFF.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset, and until the first load strobe, `out` is 0 and `count` is 0, whatever `tickEn` and `gate` do.
- R2: A load strobe captures `modeSel` and `bcdSel`, with mode codes 6 and 7 acting as modes 2 and 3. In the cycle after the load, `count` shows the initial value. A loaded zero stands for a full count of 65536 (binary, seen as 0x0000) or 10000 (BCD, seen as 0x2710).
- R3: In modes 0, 1, 4 and 5 the counter never stops. The tick after it reaches 0, it shows 0xFFFF (binary) or 0x270F (BCD) and keeps decrementing.
- R4: In modes 0 and 4, ticks count only while `gate` is high. In modes 1, 2, 3 and 5, the gate level has no effect on counting.
- R5: In modes 1, 2, 3 and 5, a rising edge of `gate` (low in the previous cycle, high now) reloads the initial count and returns `out` to its post-load level. A tick in that same cycle is not counted. In modes 0 and 4, a rising edge does nothing beyond its level.
- R6: In mode 0, `out` is 0 after a load and goes to 1 once N ticks (N = full count) have been counted. It then stays at 1 until the next load.
- R7: In mode 1, `out` is 0 while fewer than N ticks have been counted since the load or the last restart, and 1 after that.
- R8: In mode 2, the count runs N down to 1 and then reloads N. `out` is 1 for exactly the one tick period that begins when the elapsed ticks reach a nonzero multiple of N, and 0 otherwise.
- R9: In mode 3, `out` is 1 for the first ceil(N/2) ticks of each period and 0 for the remaining floor(N/2) ticks. The count starts each half at twice that half's length and drops by 2 per tick, so it is always even. With N = 1, `out` stays at 1.
- R10: In modes 4 and 5, `out` is 1 for exactly one tick period, starting when the elapsed ticks equal N. This happens once per load or restart, even after the counter wraps.
- R11: A load strobe takes priority over a tick and a gate edge in the same cycle. The elapsed count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count tick, one count per high cycle |
| gate | input | 1 | Gate level, sampled every clock |
| loadStb | input | 1 | Load initial count and mode |
| loadVal | input | 16 | Initial count |
| modeSel | input | 3 | Operating mode, captured on load |
| bcdSel | input | 1 | Select decimal full-count and wrap values |
| count | output | 16 | Current count value |
| out | output | 1 | Channel output |

## Verification
The assertions assume that `gate`, `tickEn` and the load fields are synchronous to `clk`. They also assume that `modeSel` matters only in a cycle where `loadStb` is high. The stimulus therefore changes every input at the falling edge and holds `gate` steady for several cycles between toggles. Random loads stay within 1 to 12, so that periodic and one-shot behaviours complete many times within the run. The full-count and wrap corners for both number systems are reached only by the long directed runs.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [2:0] {
    CM_TERM     = 3'd0,
    CM_ONESHOT  = 3'd1,
    CM_RATE     = 3'd2,
    CM_SQUARE   = 3'd3,
    CM_SWSTROBE = 3'd4,
    CM_HWSTROBE = 3'd5
  } ctrMode_e;

  typedef struct packed {
    logic load;
    logic restart;
    logic step;
  } ctrStrobe_t;

  function automatic ctrMode_e normMode(input logic [2:0] sel);
    case (sel)
      3'd6:    return CM_RATE;
      3'd7:    return CM_SQUARE;
      default: return ctrMode_e'(sel);
    endcase
  endfunction

  function automatic logic isRetrig(input ctrMode_e m);
    return (m == CM_ONESHOT) || (m == CM_RATE) || (m == CM_SQUARE) || (m == CM_HWSTROBE);
  endfunction

  function automatic int unsigned pow10(input int unsigned n);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       gate,
  input  logic       loadStb,
  input  logic [2:0] modeSel,
  output ctrStrobe_t strb,
  output ctrMode_e   curMode,
  output logic       armed
);

  logic     gatePrevQ;
  logic     armedQ;
  ctrMode_e modeQ;
  logic     gateRise;
  logic     retrig;
  logic     doRestart;

  assign gateRise  = gate & ~gatePrevQ;
  assign retrig    = isRetrig(modeQ);
  assign doRestart = !loadStb && armedQ && gateRise && retrig;

  always_comb begin
    strb.load    = loadStb;
    strb.restart = doRestart;
    strb.step    = !loadStb && !doRestart && armedQ && tickEn && (gate || retrig);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gatePrevQ <= 1'b0;
      armedQ    <= 1'b0;
      modeQ     <= CM_TERM;
    end else begin
      gatePrevQ <= gate;
      if (loadStb) begin
        armedQ <= 1'b1;
        modeQ  <= normMode(modeSel);
      end
    end
  end

  assign curMode = modeQ;
  assign armed   = armedQ;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loadStb |=> (armedQ && modeQ == normMode($past(modeSel))));

endmodule

// File: rtl/icc_dpath.sv
module icc_dpath
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrStrobe_t       strb,
  input  ctrMode_e         curMode,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [2:0]       modeSel,
  input  logic             bcdSel,
  output logic [CNT_W-1:0] count,
  output logic             out
);

  localparam int          CW       = CNT_W + 1;
  localparam int unsigned BCD_TOP  = pow10(CNT_W / 4);
  localparam logic [CW-1:0] BIN_FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] DEC_FULL = CW'(BCD_TOP);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] TWO      = CW'(2);

  logic          bcdQ;
  logic [CW-1:0] initQ;
  logic [CW-1:0] cntQ;
  logic          outQ;
  logic          doneQ;

  logic [CW-1:0] fullLoad;
  logic [CW-1:0] loadSq;
  logic [CW-1:0] hiReload;
  logic [CW-1:0] loReload;
  logic [CW-1:0] wrapVal;
  logic [CW-1:0] decOne;
  ctrMode_e      loadMode;

  assign loadMode = normMode(modeSel);
  assign fullLoad = (loadVal == '0) ? (bcdSel ? DEC_FULL : BIN_FULL) : {1'b0, loadVal};
  assign loadSq   = fullLoad + {{(CW-1){1'b0}}, fullLoad[0]};
  assign hiReload = initQ + {{(CW-1){1'b0}}, initQ[0]};
  assign loReload = {initQ[CW-1:1], 1'b0};
  assign wrapVal  = bcdQ ? (DEC_FULL - ONE) : (BIN_FULL - ONE);
  assign decOne   = (cntQ == '0) ? wrapVal : (cntQ - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcdQ  <= 1'b0;
      initQ <= '0;
      cntQ  <= '0;
      outQ  <= 1'b0;
      doneQ <= 1'b0;
    end else if (strb.load) begin
      bcdQ  <= bcdSel;
      initQ <= fullLoad;
      doneQ <= 1'b0;
      cntQ  <= (loadMode == CM_SQUARE) ? loadSq : fullLoad;
      outQ  <= (loadMode == CM_SQUARE);
    end else if (strb.restart) begin
      doneQ <= 1'b0;
      cntQ  <= (curMode == CM_SQUARE) ? hiReload : initQ;
      outQ  <= (curMode == CM_SQUARE);
    end else if (strb.step) begin
      case (curMode)
        CM_TERM, CM_ONESHOT: begin
          cntQ <= decOne;
          if (cntQ == ONE) outQ <= 1'b1;
        end
        CM_RATE: begin
          if (cntQ == ONE) begin
            cntQ <= initQ;
            outQ <= 1'b1;
          end else begin
            cntQ <= cntQ - ONE;
            outQ <= 1'b0;
          end
        end
        CM_SQUARE: begin
          if (cntQ == TWO) begin
            if (outQ && initQ != ONE) begin
              outQ <= 1'b0;
              cntQ <= loReload;
            end else begin
              outQ <= 1'b1;
              cntQ <= hiReload;
            end
          end else begin
            cntQ <= cntQ - TWO;
          end
        end
        default: begin
          cntQ <= decOne;
          if (cntQ == ONE && !doneQ) begin
            outQ  <= 1'b1;
            doneQ <= 1'b1;
          end else begin
            outQ <= 1'b0;
          end
        end
      endcase
    end
  end

  assign count = cntQ[CNT_W-1:0];
  assign out   = outQ;

  // R6
  term_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == CM_TERM && outQ && !strb.load) |=> outQ);

  // R8
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == CM_RATE && outQ && strb.step && initQ != ONE) |=> !outQ);

  // R9
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == CM_SQUARE) |-> !cntQ[0]);

  // R10
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((curMode == CM_SWSTROBE || curMode == CM_HWSTROBE) && outQ && strb.step) |=> !outQ);

endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             gate,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [2:0]       modeSel,
  input  logic             bcdSel,
  output logic [CNT_W-1:0] count,
  output logic             out
);

  ctrStrobe_t strbW;
  ctrMode_e   modeW;
  logic       armedW;

  icc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tickEn  (tickEn),
    .gate    (gate),
    .loadStb (loadStb),
    .modeSel (modeSel),
    .strb    (strbW),
    .curMode (modeW),
    .armed   (armedW)
  );

  icc_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strbW),
    .curMode (modeW),
    .loadVal (loadVal),
    .modeSel (modeSel),
    .bcdSel  (bcdSel),
    .count   (count),
    .out     (out)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armedW |-> (!out && count == '0));

endmodule

// File: tb/sim_interval_counter_channel.sv
module sim_interval_counter_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tickEn, gate, loadStb, bcdSel;
  logic [15:0] loadVal;
  logic [2:0]  modeSel;
  logic [15:0] count;
  logic        out;

  int    nTests = 0;
  int    nFail  = 0;
  int    cycles = 0;
  bit    ended  = 0;

  int     mMode  = 0;
  longint mF     = 1;
  longint d      = 0;
  bit     mArmed = 0;
  bit     mBcd   = 0;
  bit     mGPrev = 0;

  always #10 clk = ~clk;

  interval_counter_channel u0 (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .gate(gate), .loadStb(loadStb),
    .loadVal(loadVal), .modeSel(modeSel), .bcdSel(bcdSel), .count(count), .out(out)
  );

  function automatic bit retrigMode(input int m);
    return (m == 1) || (m == 2) || (m == 3) || (m == 5);
  endfunction

  function automatic void expected(output bit eo, output int ec);
    longint w, r, p, h, l, c;
    if (!mArmed) begin
      eo = 0; ec = 0;
      return;
    end
    w = mBcd ? 9999 : 65535;
    c = 0; eo = 0;
    case (mMode)
      2: begin
        c  = mF - (d % mF);
        eo = (d != 0) && ((d % mF) == 0);
      end
      3: begin
        p = d % mF; h = (mF + 1) / 2; l = mF / 2;
        if (p < h) begin c = 2*h - 2*p; eo = 1; end
        else begin c = 2*l - 2*(p - h); eo = 0; end
      end
      default: begin
        if (d < mF) c = mF - d;
        else begin
          r = (d - mF) % (w + 1);
          c = (r == 0) ? 0 : (w + 1 - r);
        end
        eo = (mMode <= 1) ? (d >= mF) : (d == mF);
      end
    endcase
    ec = int'(c & 64'hFFFF);
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    nTests++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  task automatic compareNow(input string tag);
    bit eo;
    int ec;
    expected(eo, ec);
    chk(tag, "out", int'(out), int'(eo));
    chk(tag, "count", int'(count), ec);
  endtask

  task automatic cyc(input bit tk, input bit gt, input bit ld, input logic [15:0] v,
                     input int m, input bit b, input string tag);
    bit rise;
    tickEn = tk; gate = gt; loadStb = ld; loadVal = v; modeSel = m[2:0]; bcdSel = b;
    rise = gt && !mGPrev;
    if (ld) begin
      mMode  = (m == 6) ? 2 : (m == 7) ? 3 : m;
      mBcd   = b;
      mF     = (v == 0) ? (b ? 10000 : 65536) : longint'(v);
      d      = 0;
      mArmed = 1;
    end else if (mArmed && rise && retrigMode(mMode)) begin
      d = 0;
    end else if (mArmed && tk && (gt || retrigMode(mMode))) begin
      d++;
    end
    mGPrev = gt;
    @(posedge clk);
    @(negedge clk);
    compareNow(tag);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !ended) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finishRun();
    end
  end

  initial begin
    bit g;
    void'($urandom(32'd4242));
    rst_n = 0; tickEn = 0; gate = 0; loadStb = 0; loadVal = 0; modeSel = 0; bcdSel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compareNow("R1");
    for (int i = 0; i < 6; i++) cyc(1, i[0], 0, 16'd0, 0, 0, "R1");

    // R6 terminal count output
    cyc(0, 1, 1, 16'd5, 0, 0, "R6");
    repeat (8) cyc(1, 1, 0, 16'd0, 0, 0, "R6");

    // R4 gate level
    cyc(0, 1, 1, 16'd6, 0, 0, "R4");
    repeat (3) cyc(1, 1, 0, 16'd0, 0, 0, "R4");
    repeat (4) cyc(1, 0, 0, 16'd0, 0, 0, "R4");
    repeat (5) cyc(1, 1, 0, 16'd0, 0, 0, "R4");
    cyc(0, 0, 1, 16'd4, 1, 0, "R4");
    repeat (6) cyc(1, 0, 0, 16'd0, 0, 0, "R4");
    cyc(0, 0, 1, 16'd3, 4, 0, "R4");
    repeat (3) cyc(1, 0, 0, 16'd0, 0, 0, "R4");

    // R2 mode aliases
    cyc(0, 0, 1, 16'd4, 6, 0, "R2");
    repeat (9) cyc(1, 0, 0, 16'd0, 0, 0, "R2");
    cyc(0, 0, 1, 16'd5, 7, 0, "R2");
    repeat (12) cyc(1, 0, 0, 16'd0, 0, 0, "R2");

    // R7 one-shot
    cyc(0, 0, 1, 16'd7, 1, 0, "R7");
    repeat (10) cyc(1, 0, 0, 16'd0, 0, 0, "R7");

    // R5 gate restart and its absence in mode 0
    cyc(0, 0, 1, 16'd6, 1, 0, "R5");
    repeat (3) cyc(1, 0, 0, 16'd0, 0, 0, "R5");
    cyc(1, 1, 0, 16'd0, 0, 0, "R5");
    repeat (8) cyc(1, 1, 0, 16'd0, 0, 0, "R5");
    cyc(0, 1, 1, 16'd6, 0, 0, "R5");
    repeat (2) cyc(1, 1, 0, 16'd0, 0, 0, "R5");
    cyc(0, 0, 0, 16'd0, 0, 0, "R5");
    repeat (5) cyc(1, 1, 0, 16'd0, 0, 0, "R5");

    // R8 rate generator
    cyc(0, 1, 1, 16'd3, 2, 0, "R8");
    repeat (10) cyc(1, 1, 0, 16'd0, 0, 0, "R8");
    cyc(0, 1, 1, 16'd1, 2, 0, "R8");
    repeat (4) cyc(1, 1, 0, 16'd0, 0, 0, "R8");

    // R9 square wave, odd and even counts
    cyc(0, 1, 1, 16'd5, 3, 0, "R9");
    repeat (12) cyc(1, 1, 0, 16'd0, 0, 0, "R9");
    cyc(0, 1, 1, 16'd1, 3, 0, "R9");
    repeat (4) cyc(1, 1, 0, 16'd0, 0, 0, "R9");
    cyc(0, 1, 1, 16'd4, 3, 0, "R9");
    repeat (10) cyc(1, 1, 0, 16'd0, 0, 0, "R9");
    cyc(0, 1, 1, 16'd2, 3, 0, "R9");
    repeat (5) cyc(1, 1, 0, 16'd0, 0, 0, "R9");

    // R10 strobes
    cyc(0, 1, 1, 16'd3, 4, 0, "R10");
    repeat (8) cyc(1, 1, 0, 16'd0, 0, 0, "R10");
    cyc(0, 0, 1, 16'd2, 5, 0, "R10");
    repeat (2) cyc(1, 0, 0, 16'd0, 0, 0, "R10");
    cyc(1, 1, 0, 16'd0, 0, 0, "R10");
    repeat (6) cyc(1, 1, 0, 16'd0, 0, 0, "R10");

    // R11 load beats tick and gate edge
    cyc(0, 0, 0, 16'd0, 0, 0, "R11");
    cyc(1, 1, 1, 16'd9, 1, 0, "R11");
    repeat (3) cyc(1, 1, 0, 16'd0, 0, 0, "R11");
    cyc(1, 1, 1, 16'd4, 0, 0, "R11");
    repeat (5) cyc(1, 1, 0, 16'd0, 0, 0, "R11");

    // R3 full binary count with wrap, then decimal full count with wrap
    cyc(0, 1, 1, 16'd0, 0, 0, "R3");
    repeat (65540) cyc(1, 1, 0, 16'd0, 0, 0, "R3");
    cyc(0, 1, 1, 16'd0, 1, 1, "R3");
    repeat (10005) cyc(1, 1, 0, 16'd0, 0, 0, "R3");

    // mixed random stimulus, restarts included
    g = 1;
    for (int i = 0; i < 20000; i++) begin
      bit ld, tk, b;
      int m;
      logic [15:0] v;
      ld = (($urandom % 40) == 0);
      v  = 16'(1 + ($urandom % 12));
      m  = int'($urandom % 8);
      b  = bit'($urandom % 2);
      tk = (($urandom % 4) != 0);
      if (($urandom % 10) == 0) g = !g;
      cyc(tk, g, ld, v, m, b, "R5");
    end

    finishRun();
  end

endmodule